// File: doc/BRIEF.md
# Double-Buffered PWM Channel

A single pulse-width modulation channel with an N-bit counter, a programmable period and duty, a polarity choice and an enable. Software writes the period and duty values through a small write port into holding (buffer) registers. While the channel runs, those values reach the active settings only when the counter wraps, so every output period uses one complete, consistent pair of settings. While the channel is stopped, a write takes effect at once.

The counter steps only on cycles where the clock-enable input `tick` is high; a prescaler outside this block produces that pulse. The polarity input selects the level the output starts each period with. The duty count marks the point where the output flips to the other level. A read port returns the buffer contents. A build parameter can mark the channel as absent. The port then ignores writes, reads back zero and drives the output low.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: `rd_data` shows the buffer register chosen by `rd_sel` (0 selects duty, 1 selects period). After a write through `wr_en`/`wr_sel`/`wr_data` (`wr_sel` 0 is duty, 1 is period), it returns the last value written, whatever the active setting is. After reset both buffers read 0.
- R2: While `ch_en` is low, a write updates the buffer and the active setting on the same clock edge.
- R3: While `ch_en` is high, a write changes only the buffer. Both active settings take the buffer values on a wrap: a `tick` cycle in which the counter equals active period − 1, or any `tick` cycle when the active period is 0. They change at no other time.
- R4: A write in the same cycle as a wrap is included in that wrap's transfer.
- R5: The counter is held at 0 while `ch_en` is low. While enabled, it advances by one only on `tick` cycles and returns to 0 on a wrap.
- R6: With `pol` = 1 and a nonzero period, the output is high while count < duty and low otherwise. The duty value is therefore the high time.
- R7: With `pol` = 0 and a nonzero period, the output is low while count < duty and high otherwise. The duty value is therefore the low time.
- R8: While `ch_en` is low, `pwm_out` equals the inverse of `pol`.
- R9: Boundary cases. Duty ≥ period keeps the output at the start level (`pol`) for the whole period. Duty = 0 keeps it at the opposite level. Period = 0 holds it at the start level.
- R10: With `PRESENT` = 0, writes have no effect, `rd_data` is always 0 and `pwm_out` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter clock-enable pulse from an external prescaler |
| ch_en | input | 1 | Channel enable |
| pol | input | 1 | Start level of each period |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 duty, 1 period |
| wr_data | input | CNT_W | Write value |
| rd_sel | input | 1 | Read target: 0 duty, 1 period |
| rd_data | output | CNT_W | Buffer register readback |
| pwm_out | output | 1 | Modulated output |

## Verification
Two functions can fall in the same cycle: a software write and the counter wrap that transfers buffers to active settings. The bench waits until its own model counter sits at period − 1 with `tick` high and issues a write in exactly that cycle. It then checks that the next period already uses the new value. A random phase repeats the collision many times with arbitrary enable toggles. The same bench also lands writes in the cycle where `ch_en` falls or rises, and judges from the waveform whether the write went directly to the active setting or waited for a wrap.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  typedef enum logic {
    SEL_DUTY   = 1'b0,
    SEL_PERIOD = 1'b1
  } pwm_sel_e;
endpackage

// File: rtl/pwm_dbuf_counter.sv
module pwm_dbuf_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic at_end(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p);
    return (p == '0) || (c == p - ONE);
  endfunction

  assign wrap = en && tick && at_end(cnt, per_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (tick)   cnt <= cnt + ONE;
  end

  AST_CNT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R5
  AST_CNT_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(tick)) |-> $stable(cnt)); // R5
  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per_act != '0) |-> (cnt < per_act)); // R5
endmodule

// File: rtl/pwm_dbuf_regbank.sv
module pwm_dbuf_regbank
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr_en,
  input  pwm_sel_e         wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wrap,
  output logic [CNT_W-1:0] duty_buf,
  output logic [CNT_W-1:0] per_buf,
  output logic [CNT_W-1:0] duty_act,
  output logic [CNT_W-1:0] per_act
);
  logic             duty_wr, per_wr;
  logic [CNT_W-1:0] duty_nxt, per_nxt;

  assign duty_wr  = wr_en && (wr_sel == SEL_DUTY);
  assign per_wr   = wr_en && (wr_sel == SEL_PERIOD);
  assign duty_nxt = duty_wr ? wr_data : duty_buf;
  assign per_nxt  = per_wr  ? wr_data : per_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_buf <= '0;
      per_buf  <= '0;
    end else begin
      duty_buf <= duty_nxt;
      per_buf  <= per_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act <= '0;
      per_act  <= '0;
    end else if (!en) begin
      if (duty_wr) duty_act <= wr_data;
      if (per_wr)  per_act  <= wr_data;
    end else if (wrap) begin
      duty_act <= duty_nxt;
      per_act  <= per_nxt;
    end
  end

  AST_BUF_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    duty_wr |=> (duty_buf == $past(wr_data))); // R1
  AST_OFF_WRITE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && per_wr) |=> (per_act == $past(wr_data))); // R2
  AST_LOAD_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(wrap)) |-> ($stable(duty_act) && $stable(per_act))); // R3
  AST_WRAP_SEES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrap && duty_wr) |=> (duty_act == $past(wr_data))); // R4
endmodule

// File: rtl/pwm_dbuf_compare.sv
module pwm_dbuf_compare #(
  parameter int CNT_W = 8
) (
  input  logic             en,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_act,
  input  logic [CNT_W-1:0] per_act,
  output logic             first_phase,
  output logic             level
);
  function automatic logic in_first(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] d,
                                    input logic [CNT_W-1:0] p);
    if (p == '0) return 1'b1;
    return c < d;
  endfunction

  assign first_phase = in_first(cnt, duty_act, per_act);
  assign level       = en ? (first_phase ? pol : ~pol) : ~pol;

  always_comb begin
    if (en && per_act != '0 && duty_act >= per_act)
      AST_FULL_DUTY_START: assert (level == pol); // R9
    if (en && per_act != '0 && duty_act == '0)
      AST_ZERO_DUTY_OPPOSITE: assert (level == ~pol); // R9
  end
endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter bit PRESENT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ch_en,
  input  logic             pol,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             pwm_out
);
  generate
    if (PRESENT) begin : g_chan
      logic [CNT_W-1:0] duty_buf, per_buf, duty_act, per_act, cnt;
      logic             wrap, first_phase, level;

      pwm_dbuf_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ch_en),
        .tick    (tick),
        .per_act (per_act),
        .cnt     (cnt),
        .wrap    (wrap)
      );

      pwm_dbuf_regbank #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ch_en),
        .wr_en    (wr_en),
        .wr_sel   (pwm_sel_e'(wr_sel)),
        .wr_data  (wr_data),
        .wrap     (wrap),
        .duty_buf (duty_buf),
        .per_buf  (per_buf),
        .duty_act (duty_act),
        .per_act  (per_act)
      );

      pwm_dbuf_compare #(.CNT_W(CNT_W)) u_cmp (
        .en          (ch_en),
        .pol         (pol),
        .cnt         (cnt),
        .duty_act    (duty_act),
        .per_act     (per_act),
        .first_phase (first_phase),
        .level       (level)
      );

      assign rd_data = rd_sel ? per_buf : duty_buf;
      assign pwm_out = level;

      AST_OFF_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |-> (pwm_out == ~pol)); // R8
    end else begin : g_reserved
      assign rd_data = '0;
      assign pwm_out = 1'b0;

      AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data == '0) && !pwm_out); // R10
    end
  endgenerate
endmodule

// File: tb/pwm_dbuf_channel_bench.sv
`timescale 1ns/1ps
module pwm_dbuf_channel_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0, ch_en = 1'b0, pol = 1'b1;
  logic         wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data, rd_data_r;
  logic         pwm_out, pwm_out_r;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [W-1:0] m_cnt = '0, m_dbuf = '0, m_pbuf = '0, m_dact = '0, m_pact = '0;

  always #2 clk = ~clk;

  pwm_dbuf_channel #(.CNT_W(W), .PRESENT(1'b1)) u_pwm_dbuf_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ch_en(ch_en), .pol(pol),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .pwm_out(pwm_out));

  pwm_dbuf_channel #(.CNT_W(W), .PRESENT(1'b0)) u_rsv (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ch_en(ch_en), .pol(pol),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data_r), .pwm_out(pwm_out_r));

  // Expected level: start level for the first 'duty' counts of a period.
  function automatic logic exp_level(input logic [W-1:0] c, input logic [W-1:0] d,
                                     input logic [W-1:0] p, input logic pl, input logic on);
    logic early;
    if (!on) return !pl;
    early = (p == 0) ? 1'b1 : (int'(c) < int'(d));
    return early ? pl : !pl;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic dw, pw;
    logic [W-1:0] dn, pn;
    dw = wr_en && !wr_sel;
    pw = wr_en && wr_sel;
    dn = dw ? wr_data : m_dbuf;
    pn = pw ? wr_data : m_pbuf;
    if (!ch_en) begin
      if (dw) m_dact = wr_data;
      if (pw) m_pact = wr_data;
      m_cnt = 0;
    end else if (tick && (m_pact == 0 || int'(m_cnt) == int'(m_pact) - 1)) begin
      m_dact = dn;
      m_pact = pn;
      m_cnt  = 0;
    end else if (tick) begin
      m_cnt = m_cnt + 1'b1;
    end
    m_dbuf = dn;
    m_pbuf = pn;
  endtask

  // One clock: model updates at the edge, outputs compared at the next falling edge.
  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, {7'd0, pwm_out}, {7'd0, exp_level(m_cnt, m_dact, m_pact, pol, ch_en)});
    check("R1", rd_data, rd_sel ? m_pbuf : m_dbuf);
    check("R10", rd_data_r, '0);
    check("R10", {7'd0, pwm_out_r}, '0);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [W-1:0] d, input string tag);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    check("R1", rd_data, '0);
    check("R8", {7'd0, pwm_out}, 8'd0);
    pol = 1'b0; #1;
    check("R8", {7'd0, pwm_out}, 8'd1);
    pol = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: writes while off go straight to the active settings
    wr(1'b0, 8'd3, "R2");
    wr(1'b1, 8'd5, "R2");
    ch_en = 1'b1; tick = 1'b1;
    for (int i = 0; i < 12; i++) cyc("R6");

    // R3: mid-period write waits for the wrap
    wr(1'b0, 8'd1, "R3");
    for (int i = 0; i < 12; i++) cyc("R3");

    // R4: write landing in the wrap cycle
    for (int k = 0; k < 3; k++) begin
      while (int'(m_cnt) != int'(m_pact) - 1) cyc("R4");
      wr(1'b0, 8'(2 + k), "R4");
      for (int i = 0; i < 6; i++) cyc("R4");
    end

    // R7: low-time polarity
    pol = 1'b0;
    for (int i = 0; i < 12; i++) cyc("R7");

    // R5: sparse ticks
    for (int i = 0; i < 60; i++) begin
      tick = ($urandom_range(0, 2) == 0);
      cyc("R5");
    end
    tick = 1'b1;

    // R9: boundary settings, loaded while off
    ch_en = 1'b0; cyc("R8");
    pol = 1'b1;
    wr(1'b0, 8'd9, "R9"); wr(1'b1, 8'd5, "R9");
    ch_en = 1'b1; for (int i = 0; i < 10; i++) cyc("R9");
    ch_en = 1'b0; wr(1'b0, 8'd0, "R9");
    ch_en = 1'b1; for (int i = 0; i < 10; i++) cyc("R9");
    ch_en = 1'b0; wr(1'b1, 8'd0, "R9"); wr(1'b0, 8'd3, "R9");
    ch_en = 1'b1; for (int i = 0; i < 10; i++) cyc("R9");

    // R1: readback of both buffers
    wr(1'b1, 8'd7, "R1"); rd_sel = 1'b1; cyc("R1");
    rd_sel = 1'b0; cyc("R1");

    // Random mix covering all requirements
    for (int i = 0; i < 4000; i++) begin
      tick   = ($urandom_range(0, 3) != 0);
      rd_sel = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 40) == 0) ch_en = ~ch_en;
      if ($urandom_range(0, 60) == 0) pol = ~pol;
      if ($urandom_range(0, 9) == 0) begin
        wr_en = 1'b1; wr_sel = $urandom_range(0, 1) == 1;
        wr_data = 8'($urandom_range(0, 12));
      end
      cyc("R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule